// File: doc/BRIEF.md
# Butterfly Multiply-Accumulate Unit

This block performs the complementary step of an integer butterfly, as used in FFT and DCT kernels. A signed operand `a` is multiplied by a signed coefficient `b`. In the same step the product is added to one accumulator value `t_in` and subtracted from a second value `s_in`. Each of the two sums is then optionally rounded and scaled down by a shift amount `sh`. The two results come out together as `t_out` and `s_out`.

The datapath is a three-stage pipeline that accepts one operation per clock. Stage one registers the multiply. Stage two registers the two accumulations with the rounding constant already added. Stage three registers the shift and sign fill.

The accumulator width is chosen from `XLEN` when the design is elaborated:
- For `XLEN` below 64, the full double-width product is accumulated against sign-extended inputs.
- At 64, only the low `XLEN` bits of the product are used.

The block drives no status or flag outputs.

Top module: `bfly_mac`

## Requirements
- R1: `a`, `b`, `t_in` and `s_in` are two's-complement signed values, and the product is the signed product of `a` and `b`.
- R2: With `sh` = 0, `t_out` equals `t_in + a*b` and `s_out` equals `s_in - a*b`, both taken modulo 2^XLEN, with no rounding.
- R3: With `sh` > 0, the constant 2^(sh-1) is added to each accumulated value before it is shifted.
- R4: With `sh` > 0, output bit i (for i < XLEN-sh) equals bit i+sh of the rounded accumulated value. The top `sh` output bits all equal the most significant bit of the rounded accumulated value.
- R5: When XLEN < 64, the accumulator is 2*XLEN bits wide and `t_in`/`s_in` are sign-extended to it. When XLEN = 64, the accumulator is XLEN bits wide and only the low XLEN bits of the product are used.
- R6: `out_vld` is `in_vld` delayed by exactly three clocks. `t_out` and `s_out` change only in a cycle in which `out_vld` is 1, and otherwise hold their value.
- R7: While `rst` is high at a rising edge, `out_vld`, `t_out` and `s_out` are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Operands valid this cycle |
| a | input | XLEN | Signed multiplicand |
| b | input | XLEN | Signed coefficient |
| t_in | input | XLEN | Signed accumulator receiving +a*b |
| s_in | input | XLEN | Signed accumulator receiving -a*b |
| sh | input | SHW | Right-shift amount, 0 to XLEN-1 |
| out_vld | output | 1 | Results valid, three cycles after `in_vld` |
| t_out | output | XLEN | Rounded, scaled `t_in + a*b` |
| s_out | output | XLEN | Rounded, scaled `s_in - a*b` |

## Verification
The hardest case to reach is one where the sign bit of the wide accumulator disagrees with bit XLEN-1 of the sum. Only then does the sign fill show that the double-width sum, and not a truncated one, supplies the fill bits. The stimulus reaches it on purpose with a product of 32767 added to 1 under a shift of one. It is also reached in passing by a sweep that crosses every shift value with extreme operand corners: the most negative value, the most positive value, -1, 0 and 1. Rounding carries across the shift boundary are brought out by small operands with `sh` = 1, where a missing rounding constant changes the result.

// File: rtl/bfly_pkg.sv
package bfly_pkg;
  function automatic int unsigned acc_width(input int unsigned xlen);
    return (xlen < 64) ? 2 * xlen : xlen;
  endfunction
endpackage

// File: rtl/bfly_mul.sv
module bfly_mul #(
  parameter int XLEN = 16,
  parameter int AW   = 32,
  parameter int SHW  = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            vld_i,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic [XLEN-1:0] t_i,
  input  logic [XLEN-1:0] s_i,
  input  logic [SHW-1:0]  sh_i,
  output logic            vld_q,
  output logic [AW-1:0]   prod_q,
  output logic [XLEN-1:0] t_q,
  output logic [XLEN-1:0] s_q,
  output logic [SHW-1:0]  sh_q
);
  localparam int PW = 2 * XLEN;

  logic signed [PW-1:0] full_prod;

  always_comb begin
    full_prod = $signed(a) * $signed(b);
  end

  always_ff @(posedge clk) begin
    prod_q <= full_prod[AW-1:0];
    t_q    <= t_i;
    s_q    <= s_i;
    sh_q   <= sh_i;
    if (rst) vld_q <= 1'b0;
    else     vld_q <= vld_i;
  end
endmodule

// File: rtl/bfly_accum.sv
module bfly_accum #(
  parameter int XLEN = 16,
  parameter int AW   = 32,
  parameter int SHW  = 4,
  parameter bit NEG  = 1'b0
) (
  input  logic            clk,
  input  logic [AW-1:0]   prod,
  input  logic [XLEN-1:0] base,
  input  logic [SHW-1:0]  sh,
  output logic [AW-1:0]   acc_q
);
  logic [AW-1:0] base_ext;
  logic [AW-1:0] term;
  logic [AW-1:0] rnd;

  generate
    if (AW > XLEN) begin : g_wide
      assign base_ext = {{(AW-XLEN){base[XLEN-1]}}, base};
    end else begin : g_narrow
      assign base_ext = base;
    end
    if (NEG) begin : g_sub
      assign term = ~prod + AW'(1);
    end else begin : g_add
      assign term = prod;
    end
  endgenerate

  always_comb begin
    rnd = '0;
    if (sh != '0) rnd[sh - SHW'(1)] = 1'b1;
  end

  always_ff @(posedge clk) begin
    acc_q <= base_ext + term + rnd;
  end
endmodule

// File: rtl/bfly_scale.sv
module bfly_scale #(
  parameter int XLEN = 16,
  parameter int AW   = 32,
  parameter int SHW  = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            vld,
  input  logic [AW-1:0]   acc,
  input  logic [SHW-1:0]  sh,
  output logic [XLEN-1:0] res_q
);
  logic [AW-1:0]   shifted;
  logic [XLEN-1:0] res_d;

  always_comb begin
    shifted = acc >> sh;
    for (int i = 0; i < XLEN; i++) begin
      if (i < XLEN - int'(sh)) res_d[i] = shifted[i];
      else                     res_d[i] = acc[AW-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)      res_q <= '0;
    else if (vld) res_q <= res_d;
  end
endmodule

// File: rtl/bfly_mac.sv
module bfly_mac #(
  parameter int XLEN = 16,
  parameter int SHW  = $clog2(XLEN)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_vld,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic [XLEN-1:0] t_in,
  input  logic [XLEN-1:0] s_in,
  input  logic [SHW-1:0]  sh,
  output logic            out_vld,
  output logic [XLEN-1:0] t_out,
  output logic [XLEN-1:0] s_out
);
  import bfly_pkg::*;

  localparam int AW    = int'(acc_width(XLEN));
  localparam int LANES = 2;

  logic            m_vld;
  logic [AW-1:0]   m_prod;
  logic [XLEN-1:0] m_t;
  logic [XLEN-1:0] m_s;
  logic [SHW-1:0]  m_sh;
  logic            a_vld;
  logic [SHW-1:0]  a_sh;
  logic [XLEN-1:0] lane_base [LANES];
  logic [AW-1:0]   lane_acc  [LANES];
  logic [XLEN-1:0] lane_res  [LANES];

  bfly_mul #(.XLEN(XLEN), .AW(AW), .SHW(SHW)) u_mul (
    .clk(clk), .rst(rst), .vld_i(in_vld), .a(a), .b(b),
    .t_i(t_in), .s_i(s_in), .sh_i(sh),
    .vld_q(m_vld), .prod_q(m_prod), .t_q(m_t), .s_q(m_s), .sh_q(m_sh)
  );

  assign lane_base[0] = m_t;
  assign lane_base[1] = m_s;

  always_ff @(posedge clk) begin
    a_sh <= m_sh;
    if (rst) a_vld <= 1'b0;
    else     a_vld <= m_vld;
  end

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      bfly_accum #(.XLEN(XLEN), .AW(AW), .SHW(SHW), .NEG(g == 1)) u_acc (
        .clk(clk), .prod(m_prod), .base(lane_base[g]), .sh(m_sh),
        .acc_q(lane_acc[g])
      );
      bfly_scale #(.XLEN(XLEN), .AW(AW), .SHW(SHW)) u_scl (
        .clk(clk), .rst(rst), .vld(a_vld), .acc(lane_acc[g]), .sh(a_sh),
        .res_q(lane_res[g])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) out_vld <= 1'b0;
    else     out_vld <= a_vld;
  end

  assign t_out = lane_res[0];
  assign s_out = lane_res[1];
endmodule

// File: rtl/bfly_mac_chk.sv
module bfly_mac_chk #(
  parameter int XLEN = 16,
  parameter int SHW  = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            in_vld,
  input logic [XLEN-1:0] a,
  input logic [XLEN-1:0] b,
  input logic [XLEN-1:0] t_in,
  input logic [XLEN-1:0] s_in,
  input logic [SHW-1:0]  sh,
  input logic            out_vld,
  input logic [XLEN-1:0] t_out,
  input logic [XLEN-1:0] s_out
);
  logic [1:0] age;

  always_ff @(posedge clk) begin
    if (rst)            age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R7: cleared outputs right after a reset edge
  p_reset_clear_r7: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_vld && t_out == '0 && s_out == '0));

  // R6: fixed three-cycle latency of the valid strobe
  p_latency_r6: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3) |-> (out_vld == $past(in_vld, 3)));

  // R6: outputs hold when no result is delivered
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (age != 2'd0 && !out_vld) |-> ($stable(t_out) && $stable(s_out)));

  // R4: the top sh bits of each result are copies of one sign
  p_sign_fill_r4: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3 && out_vld && $past(sh, 3) != '0) |->
      ((((t_out ^ {XLEN{t_out[XLEN-1]}}) >> (XLEN - int'($past(sh, 3)))) == '0) &&
       (((s_out ^ {XLEN{s_out[XLEN-1]}}) >> (XLEN - int'($past(sh, 3)))) == '0)));

  // R2: a zero factor leaves both accumulators unchanged when unscaled
  p_zero_factor_r2: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3 && out_vld && $past(sh, 3) == '0 &&
     ($past(a, 3) == '0 || $past(b, 3) == '0)) |->
      (t_out == $past(t_in, 3) && s_out == $past(s_in, 3)));

  // R2: equal accumulators produce results summing to twice the input
  p_mirror_r2: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3 && out_vld && $past(sh, 3) == '0 && $past(t_in, 3) == $past(s_in, 3)) |->
      (XLEN'(t_out + s_out) == XLEN'({$past(t_in, 3), 1'b0})));

  // R6: no unknown values leave the block after reset
  p_known_r6: assert property (@(posedge clk) disable iff (rst)
    !$isunknown({out_vld, t_out, s_out}));
endmodule

bind bfly_mac bfly_mac_chk #(.XLEN(XLEN), .SHW(SHW)) u_chk (
  .clk(clk), .rst(rst), .in_vld(in_vld), .a(a), .b(b), .t_in(t_in),
  .s_in(s_in), .sh(sh), .out_vld(out_vld), .t_out(t_out), .s_out(s_out)
);

// File: tb/bfly_mac_test.sv
module bfly_mac_test;
  localparam int X   = 16;
  localparam int SW  = 4;
  localparam int QD  = 2048;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_vld = 1'b0;
  logic [X-1:0]  a = '0, b = '0, t_in = '0, s_in = '0;
  logic [SW-1:0] sh = '0;
  logic          out_vld;
  logic [X-1:0]  t_out, s_out;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 1'b0;
  int wp = 0, rp = 0;
  logic [X-1:0] exp_t [QD];
  logic [X-1:0] exp_s [QD];
  int           exp_c [QD];
  string        exp_g [QD];
  logic [X-1:0] prev_t, prev_s;
  bit           have_prev = 1'b0;

  always #10 clk = ~clk;

  bfly_mac #(.XLEN(X)) uut (
    .clk(clk), .rst(rst), .in_vld(in_vld), .a(a), .b(b), .t_in(t_in),
    .s_in(s_in), .sh(sh), .out_vld(out_vld), .t_out(t_out), .s_out(s_out)
  );

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [X-1:0] model(input longint acc, input int n);
    longint r;
    logic [63:0] rb;
    logic [X-1:0] o;
    r  = acc + ((n > 0) ? (64'sd1 <<< (n - 1)) : 64'sd0);
    rb = r;
    for (int i = 0; i < X; i++) o[i] = (i < X - n) ? rb[i + n] : (r < 0);
    return o;
  endfunction

  task automatic check(input string req, input string what, input logic [X-1:0] act,
                       input logic [X-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic issue(input logic [X-1:0] ia, input logic [X-1:0] ib, input logic [X-1:0] it,
                       input logic [X-1:0] is, input int n, input string tag);
    longint p;
    @(negedge clk);
    a = ia; b = ib; t_in = it; s_in = is; sh = SW'(n); in_vld = 1'b1;
    p = longint'($signed(ia)) * longint'($signed(ib));
    exp_t[wp % QD] = model(longint'($signed(it)) + p, n);
    exp_s[wp % QD] = model(longint'($signed(is)) - p, n);
    exp_c[wp % QD] = cyc;
    exp_g[wp % QD] = tag;
    wp++;
  endtask

  task automatic idle();
    @(negedge clk);
    in_vld = 1'b0;
    a = $urandom; b = $urandom; sh = SW'($urandom);
  endtask

  // monitor: R6 latency and hold, R2/R3/R4 values
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (out_vld) begin
        if (rp >= wp) begin
          checks++; fails++;
          $display("FAIL R6 unexpected result: actual out_vld 1 expected 0");
        end else begin
          check("R6", "latency", X'(cyc - exp_c[rp % QD]), X'(3));
          check(exp_g[rp % QD], "t_out", t_out, exp_t[rp % QD]);
          check(exp_g[rp % QD], "s_out", s_out, exp_s[rp % QD]);
          rp++;
        end
      end else if (have_prev) begin
        check("R6", "hold t_out", t_out, prev_t);
        check("R6", "hold s_out", s_out, prev_s);
      end
      prev_t = t_out; prev_s = s_out; have_prev = 1'b1;
    end
  end

  always @(posedge clk) begin
    if (cyc > 100000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual cycle %0d expected below 100000", cyc);
      report();
    end
  end

  localparam logic [X-1:0] CORNER [5] = '{16'h7FFF, 16'h8000, 16'hFFFF, 16'h0000, 16'h0001};

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R7", "out_vld after reset", X'(out_vld), X'(0));
    check("R7", "t_out after reset", t_out, '0);
    check("R7", "s_out after reset", s_out, '0);

    // R3: rounding carry visible at sh=1 (t: 1 -> 1, s: -1 -> 0)
    issue(16'd1, 16'd1, 16'd0, 16'd0, 1, "R3");
    // R5: wide sum 32768 keeps a positive sign fill -> 0x4000
    issue(16'd1, 16'h7FFF, 16'd1, 16'd0, 1, "R5");
    // R1: negative product, unscaled
    issue(16'hFFFD, 16'd7, 16'd100, 16'hFF00, 0, "R1");
    // R2: accumulation wraps modulo 2^XLEN
    issue(16'h7FFF, 16'h7FFF, 16'h7FFF, 16'h8000, 0, "R2");
    idle(); idle();

    for (int n = 0; n < X; n++) begin
      for (int k = 0; k < 40; k++) begin
        logic [X-1:0] va, vb, vt, vs;
        if (k < 25) begin
          va = CORNER[k % 5]; vb = CORNER[(k / 5) % 5];
          vt = CORNER[(k + n) % 5]; vs = $urandom;
        end else begin
          va = $urandom; vb = $urandom; vt = $urandom; vs = $urandom;
        end
        issue(va, vb, vt, vs, n, (n == 0) ? "R2" : "R4");
        if (k % 7 == 6) begin idle(); idle(); end
      end
    end
    idle();
    repeat (8) @(negedge clk);
    check("R6", "results delivered", X'(rp), X'(wp));
    report();
  end
endmodule